// File: doc/BRIEF.md
# Four-Plane Graphics Controller Datapath

This block sits between a byte-wide CPU port and four 8-bit bit-planes of a planar frame store. Each plane byte holds one bit of eight horizontally adjacent pixels, so a 4-bit pixel is spread across the same byte address in all four planes. Software first selects a register by writing its number to an index port, then reads or writes that register through the matching data port. These registers set how CPU bytes are turned into plane bytes.

On a CPU write the byte is transformed once for each plane and stored in every plane whose write enable is set. The transform can rotate the byte, combine it with a latch in one of four logical functions, substitute a colour or set/reset value, and merge bits under a bit mask. On a CPU read all four planes at the address are copied into internal latches. The byte returned is either one chosen plane or a per-pixel colour-match result. The planes are small internal arrays whose depth is a parameter.

Top module: `planar_gc`

## Requirements
- R1: After reset, set/reset, set/reset enable, colour compare, rotate/function, read select, mode, miscellaneous and don't-care read 0. The bit mask reads FFh, the plane write mask reads 0Fh and cpu_rdata is 00h.
- R2: The register port code is 0 for controller index, 1 for controller data, 2 for sequencer index and 3 for sequencer data. Controller data indices are: set/reset 0 (bits 3:0), set/reset enable 1 (3:0), colour compare 2 (3:0), rotate 3 (count bits 2:0, function bits 4:3), read select 4 (1:0), mode 5 (write mode bits 1:0, read mode bit 3), miscellaneous 6 (3:0), don't-care 7 (3:0) and bit mask 8 (7:0). The plane write mask is sequencer index 2, bits 3:0. Undefined bits and unused indices read 0. The controller index keeps 4 bits and the sequencer index keeps 3 bits.
- R3: In read mode 0, a read strobe places plane[read select] at mem_addr on cpu_rdata after the next clock edge. cpu_rdata holds its value while no read is strobed.
- R4: Every read loads all four latches with the four plane bytes at the address, in either read mode.
- R5: In write mode 0, the CPU byte is rotated right by the rotate count before any further step.
- R6: Function 0 passes the source unchanged. Functions 1, 2 and 3 AND, OR and XOR it with the plane's latch. This applies in write modes 0, 2 and 3.
- R7: In write mode 0, for a plane whose set/reset enable bit is 1, the source is that plane's set/reset bit copied to all 8 bits.
- R8: In write modes 0 and 2, a bit-mask bit of 1 takes the function result and a 0 keeps the latch bit.
- R9: Write mode 1 stores each plane's latch unchanged, whatever the function and bit mask.
- R10: Write mode 2 uses CPU data bit p, copied to all 8 bits, as the source for plane p.
- R11: Write mode 3 uses the plane's set/reset bit copied to 8 bits as the source. It applies the function and merges under the mask (rotated CPU byte AND bit mask).
- R12: A plane whose write-mask bit is 0 is not changed by a write.
- R13: In read mode 1, result bit i is 1 when every plane p with don't-care bit p set has bit i equal to colour compare bit p.
- R14: If read and write strobes come together, the read is done and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register port write strobe |
| reg_port | input | 2 | Register port select (index/data, controller/sequencer) |
| reg_wdata | input | 8 | Register port write data |
| reg_rdata | output | 8 | Register port read data (combinational) |
| mem_re | input | 1 | CPU memory read strobe |
| mem_we | input | 1 | CPU memory write strobe |
| mem_addr | input | ADDR_W | Plane byte address |
| mem_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Registered CPU read byte |

## Verification
The bench builds the block with a depth of 4 bytes per plane. This makes it cheap to fill every address with distinct per-plane contents and read back every plane after each write. The bench sweeps all four write modes against all eight rotate counts and all four functions, varying the set/reset, enable, bit mask and plane write mask values. It also sweeps all 256 pairs of colour compare and don't-care values in read mode 1. The small depth also lets the bench load the latches at one address and write them to another, which checks latch loading apart from the stored data.

// File: rtl/gc_pkg.sv
package gc_pkg;
  localparam int unsigned NPLANES = 4;
  localparam int unsigned BYTE_W  = 8;

  typedef logic [NPLANES-1:0][BYTE_W-1:0] plane_bus_t;

  typedef enum logic [1:0] {FN_PASS = 2'd0, FN_AND = 2'd1, FN_OR = 2'd2, FN_XOR = 2'd3} gc_fn_e;
  typedef enum logic [1:0] {WM_ROT = 2'd0, WM_LATCH = 2'd1, WM_COLOR = 2'd2, WM_MASKED = 2'd3} gc_wm_e;

  localparam logic [1:0] PORT_GC_IDX  = 2'd0;
  localparam logic [1:0] PORT_GC_DAT  = 2'd1;
  localparam logic [1:0] PORT_SEQ_IDX = 2'd2;
  localparam logic [1:0] PORT_SEQ_DAT = 2'd3;

  localparam logic [3:0] IDX_SR   = 4'd0;
  localparam logic [3:0] IDX_ESR  = 4'd1;
  localparam logic [3:0] IDX_CC   = 4'd2;
  localparam logic [3:0] IDX_ROT  = 4'd3;
  localparam logic [3:0] IDX_RMAP = 4'd4;
  localparam logic [3:0] IDX_MODE = 4'd5;
  localparam logic [3:0] IDX_MISC = 4'd6;
  localparam logic [3:0] IDX_CDC  = 4'd7;
  localparam logic [3:0] IDX_BM   = 4'd8;
  localparam logic [2:0] SEQ_IDX_WMASK = 3'd2;

  typedef struct packed {
    logic [NPLANES-1:0] sr;
    logic [NPLANES-1:0] esr;
    logic [NPLANES-1:0] cc;
    logic [1:0]         fn;
    logic [2:0]         rot;
    logic [1:0]         rmap;
    logic [1:0]         wm;
    logic               rm;
    logic [3:0]         misc;
    logic [NPLANES-1:0] cdc;
    logic [BYTE_W-1:0]  bm;
    logic [NPLANES-1:0] wmask;
  } gc_cfg_t;

  function automatic logic [BYTE_W-1:0] ror_byte(input logic [BYTE_W-1:0] d, input logic [2:0] n);
    logic [2*BYTE_W-1:0] dbl;
    dbl = {d, d} >> n;
    return dbl[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/gc_regfile.sv
module gc_regfile
  import gc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_port,
  input  logic [7:0] reg_wdata,
  output gc_cfg_t    cfg,
  output logic [3:0] gc_index,
  output logic [7:0] reg_rdata
);
  gc_cfg_t    cfg_q, cfg_d;
  logic [3:0] gidx_q, gidx_d;
  logic [2:0] sidx_q, sidx_d;

  always_comb begin
    cfg_d  = cfg_q;
    gidx_d = gidx_q;
    sidx_d = sidx_q;
    if (reg_we) begin
      case (reg_port)
        PORT_GC_IDX:  gidx_d = reg_wdata[3:0];
        PORT_SEQ_IDX: sidx_d = reg_wdata[2:0];
        PORT_SEQ_DAT: if (sidx_q == SEQ_IDX_WMASK) cfg_d.wmask = reg_wdata[3:0];
        default: begin
          case (gidx_q)
            IDX_SR:   cfg_d.sr   = reg_wdata[3:0];
            IDX_ESR:  cfg_d.esr  = reg_wdata[3:0];
            IDX_CC:   cfg_d.cc   = reg_wdata[3:0];
            IDX_ROT:  {cfg_d.fn, cfg_d.rot} = reg_wdata[4:0];
            IDX_RMAP: cfg_d.rmap = reg_wdata[1:0];
            IDX_MODE: begin
              cfg_d.wm = reg_wdata[1:0];
              cfg_d.rm = reg_wdata[3];
            end
            IDX_MISC: cfg_d.misc = reg_wdata[3:0];
            IDX_CDC:  cfg_d.cdc  = reg_wdata[3:0];
            IDX_BM:   cfg_d.bm   = reg_wdata;
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      cfg_q.bm    <= 8'hFF;
      cfg_q.wmask <= 4'hF;
      gidx_q      <= '0;
      sidx_q      <= '0;
    end else begin
      cfg_q  <= cfg_d;
      gidx_q <= gidx_d;
      sidx_q <= sidx_d;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_port)
      PORT_GC_IDX:  reg_rdata = {4'h0, gidx_q};
      PORT_SEQ_IDX: reg_rdata = {5'h00, sidx_q};
      PORT_SEQ_DAT: if (sidx_q == SEQ_IDX_WMASK) reg_rdata = {4'h0, cfg_q.wmask};
      default: begin
        case (gidx_q)
          IDX_SR:   reg_rdata = {4'h0, cfg_q.sr};
          IDX_ESR:  reg_rdata = {4'h0, cfg_q.esr};
          IDX_CC:   reg_rdata = {4'h0, cfg_q.cc};
          IDX_ROT:  reg_rdata = {3'h0, cfg_q.fn, cfg_q.rot};
          IDX_RMAP: reg_rdata = {6'h00, cfg_q.rmap};
          IDX_MODE: reg_rdata = {4'h0, cfg_q.rm, 1'b0, cfg_q.wm};
          IDX_MISC: reg_rdata = {4'h0, cfg_q.misc};
          IDX_CDC:  reg_rdata = {4'h0, cfg_q.cdc};
          IDX_BM:   reg_rdata = cfg_q.bm;
          default:  reg_rdata = 8'h00;
        endcase
      end
    endcase
  end

  assign cfg      = cfg_q;
  assign gc_index = gidx_q;
endmodule

// File: rtl/gc_write_lane.sv
module gc_write_lane
  import gc_pkg::*;
#(
  parameter int unsigned PLANE = 0
) (
  input  logic [BYTE_W-1:0] cpu_byte,
  input  logic [BYTE_W-1:0] latch,
  input  logic              sr_bit,
  input  logic              esr_bit,
  input  logic [1:0]        fn,
  input  logic [2:0]        rot,
  input  logic [1:0]        wm,
  input  logic [BYTE_W-1:0] bm,
  output logic [BYTE_W-1:0] wr_byte
);
  logic [BYTE_W-1:0] rotated, src, mask, alu;

  assign rotated = ror_byte(cpu_byte, rot);

  always_comb begin
    case (gc_wm_e'(wm))
      WM_COLOR: begin
        src  = {BYTE_W{cpu_byte[PLANE]}};
        mask = bm;
      end
      WM_MASKED: begin
        src  = {BYTE_W{sr_bit}};
        mask = rotated & bm;
      end
      default: begin
        src  = esr_bit ? {BYTE_W{sr_bit}} : rotated;
        mask = bm;
      end
    endcase
  end

  always_comb begin
    case (gc_fn_e'(fn))
      FN_AND:  alu = src & latch;
      FN_OR:   alu = src | latch;
      FN_XOR:  alu = src ^ latch;
      default: alu = src;
    endcase
  end

  assign wr_byte = (gc_wm_e'(wm) == WM_LATCH) ? latch : ((alu & mask) | (latch & ~mask));
endmodule

// File: rtl/gc_read_path.sv
module gc_read_path
  import gc_pkg::*;
(
  input  plane_bus_t         planes,
  input  logic [1:0]         rmap,
  input  logic               rm,
  input  logic [NPLANES-1:0] cc,
  input  logic [NPLANES-1:0] cdc,
  output logic [BYTE_W-1:0]  rd_byte
);
  logic [BYTE_W-1:0] match;

  always_comb begin
    for (int i = 0; i < BYTE_W; i++) begin
      match[i] = 1'b1;
      for (int p = 0; p < NPLANES; p++) begin
        if (cdc[p] && (planes[p][i] != cc[p])) match[i] = 1'b0;
      end
    end
  end

  assign rd_byte = rm ? match : planes[rmap];
endmodule

// File: rtl/planar_gc.sv
module planar_gc
  import gc_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_port,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              mem_re,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_wdata,
  output logic [7:0]        cpu_rdata
);
  gc_cfg_t            cfg;
  logic [3:0]         gc_index;
  plane_bus_t         plane_rd, lane_byte, latch_q, latch_d;
  logic [NPLANES-1:0] plane_we;
  logic [7:0]         rd_byte, rdata_q, rdata_d;
  logic               wr_go;

  gc_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_port(reg_port),
    .reg_wdata(reg_wdata), .cfg(cfg), .gc_index(gc_index), .reg_rdata(reg_rdata)
  );

  assign wr_go = mem_we & ~mem_re;

  for (genvar p = 0; p < NPLANES; p++) begin : g_plane
    logic [BYTE_W-1:0] store [DEPTH];

    gc_write_lane #(.PLANE(p)) u_lane (
      .cpu_byte(mem_wdata), .latch(latch_q[p]), .sr_bit(cfg.sr[p]), .esr_bit(cfg.esr[p]),
      .fn(cfg.fn), .rot(cfg.rot), .wm(cfg.wm), .bm(cfg.bm), .wr_byte(lane_byte[p])
    );

    assign plane_we[p] = wr_go & cfg.wmask[p];
    assign plane_rd[p] = store[mem_addr];

    always_ff @(posedge clk) begin
      if (plane_we[p]) store[mem_addr] <= lane_byte[p];
    end
  end

  gc_read_path u_rd (
    .planes(plane_rd), .rmap(cfg.rmap), .rm(cfg.rm), .cc(cfg.cc), .cdc(cfg.cdc), .rd_byte(rd_byte)
  );

  always_comb begin
    latch_d = latch_q;
    rdata_d = rdata_q;
    if (mem_re) begin
      latch_d = plane_rd;
      rdata_d = rd_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      rdata_q <= '0;
    end else begin
      latch_q <= latch_d;
      rdata_q <= rdata_d;
    end
  end

  assign cpu_rdata = rdata_q;
endmodule

// File: rtl/gc_checker.sv
module gc_checker
  import gc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       mem_re,
  input logic [7:0] cpu_rdata,
  input plane_bus_t latch_q,
  input plane_bus_t lane_byte,
  input logic [1:0] wmode,
  input logic       rmode,
  input logic [3:0] cdc,
  input logic [1:0] reg_port,
  input logic [3:0] gc_index,
  input logic [7:0] reg_rdata
);
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !mem_re |=> $stable(cpu_rdata)); // R3
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !mem_re |=> $stable(latch_q)); // R4
  AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n) (wmode == 2'd1) |-> (lane_byte == latch_q)); // R9
  AST_CC_ALL_DC:  assert property (@(posedge clk) disable iff (!rst_n) (mem_re && rmode && cdc == 4'h0) |=> (cpu_rdata == 8'hFF)); // R13
  AST_IDX_UNUSED: assert property (@(posedge clk) disable iff (!rst_n) (reg_port == 2'd1 && gc_index > 4'd8) |-> (reg_rdata == 8'h00)); // R2
endmodule

bind planar_gc gc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mem_re(mem_re), .cpu_rdata(cpu_rdata),
  .latch_q(latch_q), .lane_byte(lane_byte), .wmode(cfg.wm), .rmode(cfg.rm),
  .cdc(cfg.cdc), .reg_port(reg_port), .gc_index(gc_index), .reg_rdata(reg_rdata)
);

// File: tb/sim_planar_gc.sv
module sim_planar_gc;
  localparam int DEPTH = 4;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_port = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic mem_re = 1'b0, mem_we = 1'b0;
  logic [AW-1:0] mem_addr = '0;
  logic [7:0] mem_wdata = 8'h00;
  logic [7:0] cpu_rdata;

  int n_cmp = 0, n_bad = 0;
  int mem_m [4][DEPTH];
  int lat_m [4];
  int sh_sr, sh_esr, sh_fn, sh_rot, sh_wm, sh_bm, sh_mm, sh_cc, sh_cdc;

  always #4 clk = ~clk;

  planar_gc #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_port(reg_port), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .cpu_rdata(cpu_rdata)
  );

  task automatic chk(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic reg_wr(int port, int val);
    @(negedge clk);
    reg_we = 1'b1; reg_port = port[1:0]; reg_wdata = val[7:0];
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic gc_set(int idx, int val);
    reg_wr(0, idx);
    reg_wr(1, val);
  endtask

  task automatic gc_get(int idx, output int v);
    reg_wr(0, idx);
    reg_port = 2'd1;
    #1 v = reg_rdata;
  endtask

  function automatic int rorm(int d, int r);
    return ((d >> r) | (d << (8 - r))) & 255;
  endfunction

  function automatic int cc_exp(int a);
    int r = 0;
    for (int i = 0; i < 8; i++) begin
      bit ok = 1;
      for (int p = 0; p < 4; p++)
        if (((sh_cdc >> p) & 1) && (((mem_m[p][a] >> i) & 1) != ((sh_cc >> p) & 1))) ok = 0;
      if (ok) r |= (1 << i);
    end
    return r;
  endfunction

  task automatic mem_rd(int a, output int v);
    @(negedge clk);
    mem_re = 1'b1; mem_addr = a[AW-1:0];
    @(negedge clk);
    mem_re = 1'b0;
    v = cpu_rdata;
    for (int p = 0; p < 4; p++) lat_m[p] = mem_m[p][a];
  endtask

  task automatic mem_wr(int a, int d);
    @(negedge clk);
    mem_we = 1'b1; mem_addr = a[AW-1:0]; mem_wdata = d[7:0];
    @(negedge clk);
    mem_we = 1'b0;
    for (int p = 0; p < 4; p++) begin
      int rd = rorm(d, sh_rot);
      int s, m, f, l;
      l = lat_m[p];
      s = ((sh_esr >> p) & 1) ? (((sh_sr >> p) & 1) ? 255 : 0) : rd;
      m = sh_bm;
      if (sh_wm == 2) s = ((d >> p) & 1) ? 255 : 0;
      if (sh_wm == 3) begin s = ((sh_sr >> p) & 1) ? 255 : 0; m = rd & sh_bm; end
      case (sh_fn)
        1: f = s & l;
        2: f = s | l;
        3: f = s ^ l;
        default: f = s;
      endcase
      if ((sh_mm >> p) & 1) mem_m[p][a] = (sh_wm == 1) ? l : (((f & m) | (l & ~m)) & 255);
    end
  endtask

  task automatic program_all(int rm);
    gc_set(0, sh_sr); gc_set(1, sh_esr); gc_set(3, sh_fn * 8 + sh_rot);
    gc_set(5, sh_wm + rm * 8); gc_set(8, sh_bm);
    reg_wr(2, 2); reg_wr(3, sh_mm);
  endtask

  task automatic check_planes(int a, string tag);
    int v;
    gc_set(5, sh_wm);
    for (int p = 0; p < 4; p++) begin
      gc_set(4, p);
      mem_rd(a, v);
      chk(tag, v, mem_m[p][a]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int v;
    int exp_mask [9] = '{8'h0F, 8'h0F, 8'h0F, 8'h1F, 8'h03, 8'h0B, 8'h0F, 8'h0F, 8'hFF};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 cpu_rdata", cpu_rdata, 0);
    for (int i = 0; i < 9; i++) begin
      gc_get(i, v);
      chk("R1 gc reg", v, (i == 8) ? 8'hFF : 0);
    end
    reg_wr(2, 2); reg_port = 2'd3; #1 chk("R1 write mask", reg_rdata, 8'h0F);

    // R2: register widths, unused indices, index widths
    for (int i = 0; i < 16; i++) begin
      gc_set(i, 8'hFF); gc_get(i, v);
      chk("R2 gc data", v, (i < 9) ? exp_mask[i] : 0);
    end
    reg_wr(0, 8'hFF); reg_port = 2'd0; #1 chk("R2 gc index", reg_rdata, 8'h0F);
    for (int i = 0; i < 8; i++) begin
      reg_wr(2, i); reg_wr(3, 8'hFF); reg_port = 2'd3;
      #1 chk("R2 seq data", reg_rdata, (i == 2) ? 8'h0F : 0);
    end
    reg_wr(2, 8'hFF); reg_port = 2'd2; #1 chk("R2 seq index", reg_rdata, 8'h07);
    gc_set(2, 0); gc_set(7, 0); gc_set(6, 0);

    // R12 R3: fill planes one at a time through the write mask
    sh_sr = 0; sh_esr = 0; sh_fn = 0; sh_rot = 0; sh_wm = 0; sh_bm = 255; sh_cc = 0; sh_cdc = 0;
    for (int p = 0; p < 4; p++) begin
      sh_mm = 1 << p;
      program_all(0);
      for (int a = 0; a < DEPTH; a++) mem_wr(a, (a * 29 + p * 71 + 5) & 255);
    end
    for (int a = 0; a < DEPTH; a++) check_planes(a, "R12 R3 plane fill");

    // R3: output holds without a read
    gc_set(4, 1); mem_rd(2, v);
    repeat (3) @(negedge clk);
    chk("R3 hold", cpu_rdata, mem_m[1][2]);

    // Write-mode sweep
    for (int wm = 0; wm < 4; wm++)
      for (int rot = 0; rot < 8; rot++)
        for (int fn = 0; fn < 4; fn++) begin
          int k = wm * 32 + rot * 4 + fn;
          int d = (k * 53 + 17) & 255;
          int a = k % DEPTH;
          string tag;
          sh_wm = wm; sh_rot = rot; sh_fn = fn;
          sh_sr = k & 15; sh_esr = (k * 7) & 15; sh_bm = (k * 37 + 91) & 255;
          sh_mm = (k * 5 + 3) & 15;
          program_all(0);
          mem_rd((k + 1) % DEPTH, v);
          mem_wr(a, d);
          case (wm)
            0: tag = "R5 R6 R7 R8 R12 mode0";
            1: tag = "R9 mode1";
            2: tag = "R10 R6 R8 mode2";
            default: tag = "R11 R6 mode3";
          endcase
          check_planes(a, tag);
        end

    // R4: latches load during a colour-compare read
    sh_wm = 1; sh_mm = 15; sh_cc = 5; sh_cdc = 3;
    gc_set(2, sh_cc); gc_set(7, sh_cdc);
    program_all(1);
    mem_rd(0, v);
    chk("R4 R13 compare read", v, cc_exp(0));
    gc_set(5, 1);
    mem_wr(3, 8'h5A);
    check_planes(3, "R4 latch copy");

    // R13: colour compare sweep
    sh_wm = 0;
    gc_set(5, 8);
    for (int c = 0; c < 16; c++)
      for (int dc = 0; dc < 16; dc++) begin
        int a = (c + dc) % DEPTH;
        sh_cc = c; sh_cdc = dc;
        gc_set(2, c); gc_set(7, dc);
        mem_rd(a, v);
        chk("R13 compare", v, cc_exp(a));
      end

    // R14: simultaneous read and write
    sh_wm = 0; sh_fn = 0; sh_rot = 0; sh_esr = 0; sh_bm = 255; sh_mm = 15;
    program_all(0);
    gc_set(4, 2);
    @(negedge clk);
    mem_re = 1'b1; mem_we = 1'b1; mem_addr = 2'd1; mem_wdata = ~mem_m[0][1][7:0];
    @(negedge clk);
    mem_re = 1'b0; mem_we = 1'b0;
    chk("R14 read wins", cpu_rdata, mem_m[2][1]);
    for (int p = 0; p < 4; p++) lat_m[p] = mem_m[p][1];
    check_planes(1, "R14 write dropped");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule